// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Qualification

This block is the digital front end of a clock-multiplying loop. One of two reference clocks is picked by a select input, and its rising edges are compared with the rising edges of a feedback clock. The comparison produces an `up` command when the reference edge arrives first and a `dn` command when the feedback edge arrives first. Once both commands are active they are withdrawn together, so the length of the leading pulse measures the phase error. The commands are meant for a charge pump that sits outside this block.

Everything runs on a fast sampling clock. The two reference inputs, the feedback input and the select input each pass through a two-flop synchronizer. Only rising edges are compared, so the duty cycle of the reference does not matter.

A lock flag tells a monitor that the loop has settled. The flag rises after a set number of consecutive edge pairs have fallen inside a small alignment window. It falls at once when any of the following happens:
- a pair falls outside the window;
- the reference select changes;
- the loop-enable input goes low.

The flag is for monitoring only.

Top module: `pfd_lock_detect`

## Requirements
- R1: With `ref_pick` = 0 the detector follows `ref_a`; with `ref_pick` = 1 it follows `ref_b`. Edges on the input that is not selected never raise `up` and never disturb the lock state.
- R2: A rising edge on the selected reference pin raises `up` three sample-clock edges later. A rising edge on `fb_clk` raises `dn` three sample-clock edges later. The three edges are two synchronizer stages plus the command register.
- R3: In the cycle after `up` and `dn` are first seen high together, both return low together.
- R4: Only rising edges matter. Any reference high time of one sample cycle or more gives the same result.
- R5: A pair is aligned when the gap between the reference edge and the feedback edge, in sample cycles, is no more than ALIGN_MAX (default 2). The feedback edge may lead or lag.
- R6: `locked` rises after LOCK_COUNT (default 16) consecutive aligned pairs. It stays high while pairs remain aligned.
- R7: When a lone `up` or `dn` pulse lasts longer than ALIGN_MAX cycles, the lock count clears and `locked` goes low before the pair completes.
- R8: While `loop_en` is low, `locked` is low in the same cycle and the count is held at zero. After `loop_en` returns high, a full LOCK_COUNT of new aligned pairs is needed.
- R9: A change of `ref_pick` clears the count. `locked` is low within four sample-clock edges of the change at the pin.
- R10: While `rst_n` is low, `up`, `dn` and `locked` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_a | input | 1 | Reference clock, selected when `ref_pick` = 0 |
| ref_b | input | 1 | Reference clock, selected when `ref_pick` = 1 |
| ref_pick | input | 1 | Reference select |
| fb_clk | input | 1 | Feedback clock |
| loop_en | input | 1 | Loop enable; low forces `locked` low |
| up | output | 1 | Pump-up command, reference edge leads |
| dn | output | 1 | Pump-down command, feedback edge leads |
| locked | output | 1 | Lock flag |

## Verification
Edge pairs are sent with offsets drawn at random from minus three to plus three sample cycles. This covers a feedback edge that leads, lags or coincides with the reference edge, and it separates gaps inside the window from gaps just outside it. The reference high time is also drawn at random, which shows that only rising edges count. While pairs run, the unselected reference toggles at random, which shows that the select mux isolates it. Directed cases exercise the following:
- the exact three-cycle command latency;
- the joint clear of both commands;
- the transition of the lock count from 15 to 16;
- dropping `loop_en`;
- switching the reference select while locked.

// File: rtl/pfd_lock_detect.sv
module pfd_lock_detect #(
  parameter int ALIGN_MAX  = 2,
  parameter int LOCK_COUNT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_a,
  input  logic ref_b,
  input  logic ref_pick,
  input  logic fb_clk,
  input  logic loop_en,
  output logic up,
  output logic dn,
  output logic locked
);
  localparam int WW = $clog2(ALIGN_MAX + 2);
  localparam int CW = $clog2(LOCK_COUNT + 1);

  logic [1:0]    s_a, s_b, s_pick, s_fb;
  logic          pick_q, ref_q, fb_q, up_q, dn_q;
  logic [WW-1:0] wid;
  logic [CW-1:0] cnt;

  wire ref_now  = s_pick[1] ? s_b[1] : s_a[1];
  wire ref_rise = ref_now & ~ref_q;
  wire fb_rise  = s_fb[1] & ~fb_q;
  wire both     = up_q & dn_q;
  wire single   = up_q ^ dn_q;
  wire pick_chg = s_pick[1] ^ pick_q;
  wire late     = single && (wid == WW'(ALIGN_MAX));
  wire aligned  = both && (wid <= WW'(ALIGN_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_a <= '0; s_b <= '0; s_pick <= '0; s_fb <= '0;
      pick_q <= 1'b0; ref_q <= 1'b0; fb_q <= 1'b0;
    end else begin
      s_a    <= {s_a[0], ref_a};
      s_b    <= {s_b[0], ref_b};
      s_pick <= {s_pick[0], ref_pick};
      s_fb   <= {s_fb[0], fb_clk};
      pick_q <= s_pick[1];
      ref_q  <= ref_now;
      fb_q   <= s_fb[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (both) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_q | ref_rise;
      dn_q <= dn_q | fb_rise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wid <= '0;
    else if (both)
      wid <= '0;
    else if (single && wid != WW'(ALIGN_MAX + 1))
      wid <= wid + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!loop_en || pick_chg || late)
      cnt <= '0;
    else if (aligned && cnt != CW'(LOCK_COUNT))
      cnt <= cnt + 1'b1;
  end

  assign up     = up_q;
  assign dn     = dn_q;
  assign locked = loop_en && (cnt == CW'(LOCK_COUNT));

  AST_PAIR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (up && dn) |=> (!up && !dn)); // R3
  AST_UP_FROM_REF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up) |-> $past(ref_rise)); // R2
  AST_LATE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    late |=> !locked); // R7
  AST_PICK_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    pick_chg |=> !locked); // R9
  AST_LOCK_AFTER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(both) || $rose(loop_en))); // R6
endmodule

// File: tb/test_pfd_lock_detect.sv
`timescale 1ns/1ps
module test_pfd_lock_detect;
  localparam int ALIGN = 2;
  localparam int NLOCK = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_a = 1'b0, ref_b = 1'b0, ref_pick = 1'b0, fb_clk = 1'b0, loop_en = 1'b1;
  logic up, dn, locked;
  int total = 0, bad = 0, exp_cnt = 0;
  bit done = 1'b0;

  pfd_lock_detect #(.ALIGN_MAX(ALIGN), .LOCK_COUNT(NLOCK)) i_pfd_lock_detect (
    .clk(clk), .rst_n(rst_n), .ref_a(ref_a), .ref_b(ref_b), .ref_pick(ref_pick),
    .fb_clk(fb_clk), .loop_en(loop_en), .up(up), .dn(dn), .locked(locked));

  always #2.5 clk = ~clk;

  function automatic bit is_aligned(int d);
    return ((d < 0) ? -d : d) <= ALIGN;
  endfunction

  function automatic int next_cnt(int c, int d);
    if (!is_aligned(d)) return 0;
    return (c < NLOCK) ? c + 1 : c;
  endfunction

  task automatic chk(logic got, logic exp, string req, string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, got, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pair(int d, int hi, bit noise, string req);
    int rs, fs;
    rs = (d >= 0) ? 2 : 2 - d;
    fs = (d >= 0) ? 2 + d : 2;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      if (ref_pick) begin
        ref_b = (c >= rs) && (c < rs + hi);
        if (noise) ref_a = 1'($urandom_range(0, 1));
      end else begin
        ref_a = (c >= rs) && (c < rs + hi);
        if (noise) ref_b = 1'($urandom_range(0, 1));
      end
      fb_clk = (c >= fs) && (c < fs + 4);
    end
    ref_a = 1'b0; ref_b = 1'b0;
    exp_cnt = next_cnt(exp_cnt, d);
    chk(locked, 1'(exp_cnt == NLOCK), req, $sformatf("lock after pair d=%0d hi=%0d", d, hi));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    cyc(3);
    chk(up, 1'b0, "R10", "up in reset");
    chk(dn, 1'b0, "R10", "dn in reset");
    chk(locked, 1'b0, "R10", "locked in reset");
    rst_n = 1'b1;
    cyc(2);

    // R2 R3: reference leads by two cycles
    ref_a = 1'b1; cyc(2); fb_clk = 1'b1; cyc(1);
    chk(up, 1'b1, "R2", "up after three edges");
    chk(dn, 1'b0, "R2", "dn still low");
    cyc(2);
    chk(dn, 1'b1, "R2", "dn after three edges");
    chk(up, 1'b1, "R3", "up held until dn");
    cyc(1);
    chk(up, 1'b0, "R3", "up cleared");
    chk(dn, 1'b0, "R3", "dn cleared");
    ref_a = 1'b0; fb_clk = 1'b0; cyc(8);
    exp_cnt = next_cnt(exp_cnt, 2);

    // R3: coincident edges
    ref_a = 1'b1; fb_clk = 1'b1; cyc(3);
    chk(up & dn, 1'b1, "R3", "both high together");
    cyc(1);
    chk(up | dn, 1'b0, "R3", "both cleared together");
    ref_a = 1'b0; fb_clk = 1'b0; cyc(8);
    exp_cnt = next_cnt(exp_cnt, 0);

    // R4 R5 R6: aligned pairs, random phase and duty, noise on ref_b
    for (int k = 0; k < 14; k++)
      pair($urandom_range(0, 4) - 2, $urandom_range(1, 8), 1'b1, "R6");
    chk(locked, 1'b1, "R4", "locked with random duty");
    pair(3, 3, 1'b0, "R7");
    pair(0, 1, 1'b0, "R7");

    // mixed random phases
    for (int k = 0; k < 40; k++) begin
      int d;
      d = ($urandom_range(0, 7) == 0) ? (($urandom_range(0, 1) != 0) ? 3 : -3)
                                      : $urandom_range(0, 4) - 2;
      pair(d, $urandom_range(1, 8), 1'b1, "R5");
    end
    for (int k = 0; k < NLOCK; k++) pair(-2, 2, 1'b0, "R6");
    chk(locked, 1'b1, "R6", "locked after full run");

    // R8: loop disable
    loop_en = 1'b0; #1;
    chk(locked, 1'b0, "R8", "locked drops with loop_en");
    cyc(3); exp_cnt = 0; loop_en = 1'b1; #1;
    chk(locked, 1'b0, "R8", "no lock right after enable");
    for (int k = 0; k < NLOCK; k++) pair(1, 4, 1'b0, "R8");

    // R9: select change
    ref_pick = 1'b1; cyc(4);
    chk(locked, 1'b0, "R9", "select change unlocks");
    exp_cnt = 0;
    for (int k = 0; k < NLOCK; k++) pair($urandom_range(0, 4) - 2, 5, 1'b1, "R1");

    // R1: lone edge on unselected input
    ref_a = 1'b1; cyc(3); ref_a = 1'b0;
    for (int k = 0; k < 6; k++) begin
      cyc(1);
      chk(up, 1'b0, "R1", "unselected edge raises up");
    end
    chk(locked, 1'b1, "R1", "lock kept after unselected edge");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule